// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Serial Converter Register Interface

This block is the digital front end of a two-channel 12-bit converter. A host shifts a code word in over a three-wire serial link (data, clock, active-low select) into a single input shift register. Two output registers, one per channel, take that word when their own active-low load strobe is driven low. The serial register can therefore be preloaded with a new code while both channel outputs stay untouched.

An asynchronous-style preset input forces both channel registers to zero or to half scale, chosen by a mode pin. A shutdown input blanks both channel outputs and drops their powered flags. The register contents are kept, and loading goes on while the outputs are blanked. A sticky flag reports the forbidden case of shifting while a load strobe is low. Every pin is sampled by a fast system clock through two-flop synchronizers, and the serial clock edge is found from the synchronized copy.

Top module: `dual_dac_ctrl`

## Requirements
- R1: The shift register moves by one bit only on a rising serial clock edge seen while chipSelN is low. Rising edges while chipSelN is high leave it unchanged.
- R2: Bits enter most significant first. When more than 12 bits are clocked in one select period, the last 12 bits received form the word, with the last bit as bit 0.
- R3: While a load strobe is low, its channel register follows the shift register. After the strobe returns high, the register holds its value through later shifts.
- R4: The load strobes work regardless of chipSelN. A channel loads while chipSelN is high.
- R5: While presetN is low, both channel registers read 0x800 if halfMode is 1 and 0x000 if halfMode is 0. A load strobe held low during the preset has no effect.
- R6: A channel whose load strobe is still low when presetN returns high takes the shift register contents. The other channel keeps its preset value.
- R7: While sleepN is low, chanA and chanB read 0 and powerA and powerB read 0. Stored values are kept and loads still take effect. After release, each output shows its current register value.
- R8: protoErr goes to 1 when a shift occurs while either load strobe is low. It then stays at 1 until the system reset.
- R9: The synchronous reset rst (active high) clears the shift register, both channel registers and protoErr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous system reset, active high |
| serData | input | 1 | Serial data, most significant bit first |
| serClk | input | 1 | Serial clock, data taken on rising edge |
| chipSelN | input | 1 | Active-low select that enables shifting |
| loadAN | input | 1 | Active-low level load strobe for channel A |
| loadBN | input | 1 | Active-low level load strobe for channel B |
| presetN | input | 1 | Active-low preset of both channel registers |
| halfMode | input | 1 | Preset value select: 1 gives 0x800, 0 gives 0x000 |
| sleepN | input | 1 | Active-low shutdown |
| chanA | output | 12 | Channel A code, 0 in shutdown |
| chanB | output | 12 | Channel B code, 0 in shutdown |
| powerA | output | 1 | Channel A powered flag |
| powerB | output | 1 | Channel B powered flag |
| protoErr | output | 1 | Sticky flag for a shift while a strobe is low |

## Verification
The load path is exercised with exact 12-bit frames, with 16- and 20-bit frames whose leading bits must be dropped, and with all-ones, all-zeros, lone-LSB and lone-MSB codes. These patterns separate a correct shift order and truncation from a reversed, misaligned or stuck bit. A frame clocked with the select high, followed by a load, shows whether shifting is gated. Transparent-strobe, preset with both mode values, strobe-held-through-preset and shutdown-with-loading sequences each give an output that differs from what a design lacking that rule would show. A deliberate shift during a low strobe, followed by a reset, checks that the error flag is set, held and cleared.

// File: rtl/dual_dac_ctrl_pkg.sv
package dual_dac_ctrl_pkg;
  localparam int DATA_W = 12;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic              shift;
    logic              bitIn;
    logic              preset;
    logic              presetHalf;
    logic [NUM_CH-1:0] follow;
  } dacStrobe_t;
endpackage

// File: rtl/dual_dac_sync.sv
module dual_dac_sync #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] metaStage;

  always_ff @(posedge clk) begin
    if (rst) begin
      metaStage <= RST_VAL;
      syncOut   <= RST_VAL;
    end else begin
      metaStage <= rawIn;
      syncOut   <= metaStage;
    end
  end
endmodule

// File: rtl/dual_dac_ctl.sv
module dual_dac_ctl
  import dual_dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serData,
  input  logic              serClk,
  input  logic              chipSelN,
  input  logic [NUM_CH-1:0] loadN,
  input  logic              presetN,
  input  logic              halfMode,
  input  logic              sleepN,
  output dacStrobe_t        strb,
  output logic              sleepOn,
  output logic              protoErr
);
  localparam int PIN_W = NUM_CH + 6;
  localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, 1'b0, 1'b1, {NUM_CH{1'b1}}, 1'b1, 1'b0, 1'b0};

  logic [PIN_W-1:0] rawPins;
  logic [PIN_W-1:0] syncPins;
  logic             sData, sClk, sCsN, sPresetN, sHalf, sSleepN;
  logic [NUM_CH-1:0] sLoadN;
  logic             clkPrev;
  logic             clkRise;

  assign rawPins = {sleepN, halfMode, presetN, loadN, chipSelN, serClk, serData};

  dual_dac_sync #(.WIDTH(PIN_W), .RST_VAL(PIN_IDLE)) pinSync_i (
    .clk    (clk),
    .rst    (rst),
    .rawIn  (rawPins),
    .syncOut(syncPins)
  );

  assign {sSleepN, sHalf, sPresetN, sLoadN, sCsN, sClk, sData} = syncPins;

  always_ff @(posedge clk) begin
    if (rst) clkPrev <= 1'b0;
    else     clkPrev <= sClk;
  end

  assign clkRise = sClk & ~clkPrev;

  always_comb begin
    strb.shift      = clkRise & ~sCsN;
    strb.bitIn      = sData;
    strb.preset     = ~sPresetN;
    strb.presetHalf = sHalf;
    strb.follow     = ~sLoadN & {NUM_CH{sPresetN}};
  end

  assign sleepOn = ~sSleepN;

  always_ff @(posedge clk) begin
    if (rst)                                   protoErr <= 1'b0;
    else if (strb.shift && (sLoadN != '1))     protoErr <= 1'b1;
  end

  // R8: once raised, the error flag holds until reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> protoErr);
endmodule

// File: rtl/dual_dac_dp.sv
module dual_dac_dp
  import dual_dac_ctrl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  dacStrobe_t                    strb,
  output logic [NUM_CH-1:0][DATA_W-1:0] chanReg
);
  localparam logic [DATA_W-1:0] HALF_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst)             shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[DATA_W-2:0], strb.bitIn};
  end

  // R1: no strobe, no movement
  p_shift_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !strb.shift |=> shiftReg == $past(shiftReg));

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk) begin
      if (rst)                 chanReg[g] <= '0;
      else if (strb.preset)    chanReg[g] <= strb.presetHalf ? HALF_CODE : '0;
      else if (strb.follow[g]) chanReg[g] <= shiftReg;
    end

    // R3: a transparent channel tracks the shift register
    p_follow_r3: assert property (@(posedge clk) disable iff (rst)
      strb.follow[g] |=> chanReg[g] == $past(shiftReg));

    // R3: a latched channel keeps its value
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!strb.follow[g] && !strb.preset) |=> chanReg[g] == $past(chanReg[g]));

    // R5: preset value picked by the mode bit
    p_preset_r5: assert property (@(posedge clk) disable iff (rst)
      strb.preset |=> chanReg[g] == ($past(strb.presetHalf) ? HALF_CODE : '0));
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dual_dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serData,
  input  logic              serClk,
  input  logic              chipSelN,
  input  logic              loadAN,
  input  logic              loadBN,
  input  logic              presetN,
  input  logic              halfMode,
  input  logic              sleepN,
  output logic [DATA_W-1:0] chanA,
  output logic [DATA_W-1:0] chanB,
  output logic              powerA,
  output logic              powerB,
  output logic              protoErr
);
  dacStrobe_t                    strb;
  logic                          sleepOn;
  logic [NUM_CH-1:0][DATA_W-1:0] chanReg;

  dual_dac_ctl ctl_i (
    .clk     (clk),
    .rst     (rst),
    .serData (serData),
    .serClk  (serClk),
    .chipSelN(chipSelN),
    .loadN   ({loadBN, loadAN}),
    .presetN (presetN),
    .halfMode(halfMode),
    .sleepN  (sleepN),
    .strb    (strb),
    .sleepOn (sleepOn),
    .protoErr(protoErr)
  );

  dual_dac_dp dp_i (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .chanReg(chanReg)
  );

  assign chanA  = sleepOn ? '0 : chanReg[0];
  assign chanB  = sleepOn ? '0 : chanReg[1];
  assign powerA = ~sleepOn;
  assign powerB = ~sleepOn;
endmodule

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serData = 1'b0, serClk = 1'b0, chipSelN = 1'b1;
  logic loadAN = 1'b1, loadBN = 1'b1, presetN = 1'b1, halfMode = 1'b0, sleepN = 1'b1;
  logic [11:0] chanA, chanB;
  logic powerA, powerB, protoErr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [11:0] modelA, modelB;

  always #2 clk = ~clk;

  dual_dac_ctrl dut_i (
    .clk(clk), .rst(rst), .serData(serData), .serClk(serClk), .chipSelN(chipSelN),
    .loadAN(loadAN), .loadBN(loadBN), .presetN(presetN), .halfMode(halfMode),
    .sleepN(sleepN), .chanA(chanA), .chanB(chanB), .powerA(powerA), .powerB(powerB),
    .protoErr(protoErr)
  );

  localparam int NVEC = 8;
  localparam logic [23:0] vecWord [NVEC] = '{24'h000ABC, 24'h0005A5, 24'h00F123, 24'h000FFF,
                                             24'h000000, 24'hFED987, 24'h000001, 24'h000800};
  localparam int          vecLen  [NVEC] = '{12, 12, 16, 12, 12, 20, 12, 12};
  localparam bit          vecChan [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [11:0] vecExp  [NVEC] = '{12'hABC, 12'h5A5, 12'h123, 12'hFFF,
                                             12'h000, 12'h987, 12'h001, 12'h800};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [23:0] word, input int len, input bit csHigh);
    chipSelN = csHigh;
    tick(4);
    for (int i = len - 1; i >= 0; i--) begin
      serData = word[i];
      tick(4);
      serClk = 1'b1;
      tick(4);
      serClk = 1'b0;
    end
    tick(4);
    chipSelN = 1'b1;
    tick(4);
  endtask

  task automatic pulseLoad(input bit chanSel);
    if (chanSel) loadBN = 1'b0; else loadAN = 1'b0;
    tick(8);
    loadAN = 1'b1;
    loadBN = 1'b1;
    tick(8);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(8);
    // R9: reset state
    chk("R9 reset chanA", chanA, 12'h000);
    chk("R9 reset chanB", chanB, 12'h000);
    chk("R9 reset protoErr", {11'b0, protoErr}, 12'h000);
    chk("R7 powered after reset", {10'b0, powerB, powerA}, 12'h003);

    // R2/R3/R4: vector table, loads done with select high
    modelA = 12'h000;
    modelB = 12'h000;
    for (int v = 0; v < NVEC; v++) begin
      sendFrame(vecWord[v], vecLen[v], 1'b0);
      pulseLoad(vecChan[v]);
      if (vecChan[v]) modelB = vecExp[v]; else modelA = vecExp[v];
      chk($sformatf("R2 R4 vec%0d chanA", v), chanA, modelA);
      chk($sformatf("R2 R4 vec%0d chanB", v), chanB, modelB);
    end

    // R1: edges with select high do not shift; shift register still 0x800
    sendFrame(24'h000555, 12, 1'b1);
    pulseLoad(1'b0);
    chk("R1 select-high edges ignored", chanA, 12'h800);

    // R3: transparency, then hold through later shifts
    sendFrame(24'h0003A7, 12, 1'b0);
    loadAN = 1'b0;
    tick(8);
    chk("R3 transparent while low", chanA, 12'h3A7);
    loadAN = 1'b1;
    tick(8);
    sendFrame(24'h000111, 12, 1'b0);
    chk("R3 latched after rise", chanA, 12'h3A7);

    // R5: preset both ways, overriding a low strobe
    halfMode = 1'b1;
    presetN = 1'b0;
    tick(8);
    chk("R5 half preset chanA", chanA, 12'h800);
    chk("R5 half preset chanB", chanB, 12'h800);
    halfMode = 1'b0;
    tick(8);
    chk("R5 zero preset chanA", chanA, 12'h000);
    chk("R5 zero preset chanB", chanB, 12'h000);
    loadBN = 1'b0;
    tick(8);
    chk("R5 preset overrides strobe", chanB, 12'h000);
    // R6: strobe still low at release
    presetN = 1'b1;
    tick(8);
    chk("R6 load on preset release", chanB, 12'h111);
    chk("R6 other channel stays preset", chanA, 12'h000);
    loadBN = 1'b1;
    tick(8);

    // R7: shutdown blanks, keeps and accepts loads
    sleepN = 1'b0;
    tick(8);
    chk("R7 sleep powered flags", {10'b0, powerB, powerA}, 12'h000);
    chk("R7 sleep chanB blank", chanB, 12'h000);
    sendFrame(24'h0006C3, 12, 1'b0);
    pulseLoad(1'b0);
    chk("R7 sleep chanA blank after load", chanA, 12'h000);
    sleepN = 1'b1;
    tick(8);
    chk("R7 wake chanA new value", chanA, 12'h6C3);
    chk("R7 wake chanB kept", chanB, 12'h111);
    chk("R7 wake powered", {10'b0, powerB, powerA}, 12'h003);

    // R8: shift while a strobe is low
    chk("R8 no error yet", {11'b0, protoErr}, 12'h000);
    loadBN = 1'b0;
    tick(8);
    sendFrame(24'h000222, 12, 1'b0);
    loadBN = 1'b1;
    tick(8);
    chk("R8 error raised", {11'b0, protoErr}, 12'h001);
    tick(20);
    chk("R8 error sticky", {11'b0, protoErr}, 12'h001);

    // R9: system reset clears all state
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(8);
    chk("R9 clear protoErr", {11'b0, protoErr}, 12'h000);
    chk("R9 clear chanA", chanA, 12'h000);
    chk("R9 clear chanB", chanB, 12'h000);
    pulseLoad(1'b0);
    chk("R9 shift register cleared", chanA, 12'h000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule